// File: doc/BRIEF.md
# Two-Stage Refresh Watchdog

This block watches for missed software refreshes against a free-running 64-bit system count supplied from outside. Software programs an interval in count ticks, then sets the enable bit. From then on a compare value is kept at "count plus interval". If the count reaches the compare value before a refresh arrives, the block raises an interrupt and re-arms for a second interval. If that second interval also expires with the interrupt still pending, the block raises a one-cycle reset request and sets a sticky flag. The full timeout is therefore two intervals.

There are two 32-bit register ports. The control port holds status and enable, the interval and the two halves of the compare value. The refresh port has one location; any write there restarts the interval and ignores the data. A reset-hold input sets the value of the sticky flag during reset. A reset controller outside this block can drive it, so software can still see after the reset that the watchdog caused it.

Top module: `twostage_wdog`

## Requirements
- R1: During reset (synchronous, active-low `rst_n`) enable, the first-stage flag, `irq_o`, `rst_req_o`, the interval and the compare value all clear to zero, and the second-stage flag takes the value of `s2_keep_i`.
- R2: A control write to address 0x00 sets enable from data bit 0 and always clears the first-stage flag. If bit 0 is 1, the compare value becomes count + interval. If bit 0 is 0, the watchdog stops.
- R3: When enabled, the count is at or above the compare value, the first-stage flag is clear and no write arrives on either port in that cycle, the first-stage flag sets and the compare value becomes count + interval. `irq_o` follows the first-stage flag, so with a count that rises by one per cycle `irq_o` rises at the edge where count = enable count + interval (one tick later for interval 0).
- R4: The same condition with the first-stage flag already set sets the second-stage flag, pulses `rst_req_o` high for one cycle and re-arms the compare value as count + interval. From enable, the reset request comes at 2 × interval.
- R5: A refresh-port write to address 0x00, with any data, sets the compare value to count + interval and clears the first-stage flag. Refresh writes to any other address have no effect.
- R6: A control write to address 0x08 stores the interval and sets the compare value to count + new interval.
- R7: Control writes to 0x10 and 0x14 load the low and high 32 bits of the compare value, and both halves read back at those addresses.
- R8: The second-stage flag stays set until a control write to 0x00 with data bit 2 = 1. While enable is 0, neither stage flag sets and `rst_req_o` stays low.
- R9: Control reads are combinational: address 0x00 returns enable in bit 0, the first-stage flag in bit 1 and the second-stage flag in bit 2, with zero above. Address 0x08 returns the interval. Unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s2_keep_i | input | 1 | Value loaded into the second-stage flag during reset |
| ctl_we_i | input | 1 | Control-port write strobe |
| ctl_addr_i | input | 5 | Control-port byte address |
| ctl_wdata_i | input | 32 | Control-port write data |
| ctl_rdata_o | output | 32 | Control-port read data for `ctl_addr_i` |
| ref_we_i | input | 1 | Refresh-port write strobe |
| ref_addr_i | input | 5 | Refresh-port byte address |
| ref_wdata_i | input | 32 | Refresh-port write data (ignored) |
| count_i | input | 64 | Shared system count |
| irq_o | output | 1 | First-stage interrupt |
| rst_req_o | output | 1 | Second-stage reset-request pulse |

## Verification
The interval is swept over a range of small values from a count that starts just below a 32-bit carry. For each value, the edges that raise the interrupt and the reset request are compared with enable + interval and enable + 2 × interval, which separates a single-interval timeout from a doubled or shifted one. An interval of zero checks the one-tick minimum. Refreshes before expiry and after the interrupt, an ignored refresh address, an interval rewrite and a direct compare load each move the expected expiry edge in a different way, so a wrong re-arm base shows up as a shifted edge. Sticky clearing, disabled idling and the reset-hold input are checked through status reads.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int unsigned CNT_W  = 64;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_STAT = 5'h00;
    localparam logic [ADDR_W-1:0] A_IVAL = 5'h08;
    localparam logic [ADDR_W-1:0] A_CMPL = 5'h10;
    localparam logic [ADDR_W-1:0] A_CMPH = 5'h14;
    localparam logic [ADDR_W-1:0] A_KICK = 5'h00;

    localparam int unsigned B_EN = 0;
    localparam int unsigned B_S1 = 1;
    localparam int unsigned B_S2 = 2;

    typedef struct packed {
        logic             en;
        logic             s1;
        logic             s2;
        logic             rst_req;
        logic [REG_W-1:0] ival;
        logic [CNT_W-1:0] cmp;
    } wdt_state_t;
endpackage

// File: rtl/wdt_cmp.sv
module wdt_cmp
    import wdt_pkg::*;
(
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [REG_W-1:0] ival_i,
    output logic             due_o,
    output logic [CNT_W-1:0] rearm_o
);
    localparam int unsigned PAD_W = CNT_W - REG_W;

    always_comb begin
        due_o   = (count_i >= cmp_i);
        rearm_o = count_i + {{PAD_W{1'b0}}, ival_i};
    end
endmodule

// File: rtl/wdt_rdmux.sv
module wdt_rdmux
    import wdt_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  wdt_state_t        st_i,
    output logic [REG_W-1:0]  rdata_o
);
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_STAT: begin
                rdata_o[B_EN] = st_i.en;
                rdata_o[B_S1] = st_i.s1;
                rdata_o[B_S2] = st_i.s2;
            end
            A_IVAL: rdata_o = st_i.ival;
            A_CMPL: rdata_o = st_i.cmp[REG_W-1:0];
            A_CMPH: rdata_o = st_i.cmp[CNT_W-1:REG_W];
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s2_keep_i,
    input  logic              ctl_we_i,
    input  logic [ADDR_W-1:0] ctl_addr_i,
    input  logic [REG_W-1:0]  ctl_wdata_i,
    input  logic              ref_we_i,
    input  logic [ADDR_W-1:0] ref_addr_i,
    input  logic              due_i,
    input  logic [CNT_W-1:0]  rearm_i,
    output logic [REG_W-1:0]  ival_eff_o,
    output wdt_state_t        st_o
);
    wdt_state_t st_d, st_q;
    logic stat_wr, ival_wr, cmpl_wr, cmph_wr, kick, any_wr;

    always_comb begin
        stat_wr = ctl_we_i && (ctl_addr_i == A_STAT);
        ival_wr = ctl_we_i && (ctl_addr_i == A_IVAL);
        cmpl_wr = ctl_we_i && (ctl_addr_i == A_CMPL);
        cmph_wr = ctl_we_i && (ctl_addr_i == A_CMPH);
        kick    = ref_we_i && (ref_addr_i == A_KICK);
        any_wr  = ctl_we_i || kick;
        ival_eff_o = ival_wr ? ctl_wdata_i : st_q.ival;

        st_d = st_q;
        st_d.rst_req = 1'b0;
        if (kick) begin
            st_d.s1  = 1'b0;
            st_d.cmp = rearm_i;
        end
        if (stat_wr) begin
            st_d.en = ctl_wdata_i[B_EN];
            st_d.s1 = 1'b0;
            if (ctl_wdata_i[B_EN]) st_d.cmp = rearm_i;
            if (ctl_wdata_i[B_S2]) st_d.s2 = 1'b0;
        end else if (ival_wr) begin
            st_d.ival = ctl_wdata_i;
            st_d.cmp  = rearm_i;
        end else if (cmpl_wr) begin
            st_d.cmp[REG_W-1:0] = ctl_wdata_i;
        end else if (cmph_wr) begin
            st_d.cmp[CNT_W-1:REG_W] = ctl_wdata_i;
        end
        if (!any_wr && st_q.en && due_i) begin
            st_d.cmp = rearm_i;
            if (!st_q.s1) begin
                st_d.s1 = 1'b1;
            end else begin
                st_d.s2      = 1'b1;
                st_d.rst_req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.s2 <= s2_keep_i;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_o = st_q;

    // R4
    reset_needs_s2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst_req |-> st_q.s2);
    // R4
    reset_after_s1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rst_req) |-> $past(st_q.s1));
    // R5
    kick_clears_s1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_we_i && ref_addr_i == A_KICK) |=> !st_q.s1);
    // R8
    idle_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en |=> !st_q.rst_req);
    // R8
    s2_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s2 && !(ctl_we_i && ctl_addr_i == A_STAT && ctl_wdata_i[B_S2])) |=> st_q.s2);
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s2_keep_i,
    input  logic              ctl_we_i,
    input  logic [ADDR_W-1:0] ctl_addr_i,
    input  logic [REG_W-1:0]  ctl_wdata_i,
    output logic [REG_W-1:0]  ctl_rdata_o,
    input  logic              ref_we_i,
    input  logic [ADDR_W-1:0] ref_addr_i,
    input  logic [REG_W-1:0]  ref_wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              irq_o,
    output logic              rst_req_o
);
    wdt_state_t       st;
    logic             due;
    logic [CNT_W-1:0] rearm;
    logic [REG_W-1:0] ival_eff;
    logic             unused_kick_data;

    assign unused_kick_data = ^ref_wdata_i;

    wdt_cmp u_cmp (
        .count_i (count_i),
        .cmp_i   (st.cmp),
        .ival_i  (ival_eff),
        .due_o   (due),
        .rearm_o (rearm)
    );

    wdt_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .s2_keep_i   (s2_keep_i),
        .ctl_we_i    (ctl_we_i),
        .ctl_addr_i  (ctl_addr_i),
        .ctl_wdata_i (ctl_wdata_i),
        .ref_we_i    (ref_we_i),
        .ref_addr_i  (ref_addr_i),
        .due_i       (due),
        .rearm_i     (rearm),
        .ival_eff_o  (ival_eff),
        .st_o        (st)
    );

    wdt_rdmux u_rd (
        .addr_i  (ctl_addr_i),
        .st_i    (st),
        .rdata_o (ctl_rdata_o)
    );

    assign irq_o     = st.s1;
    assign rst_req_o = st.rst_req;
endmodule

// File: tb/tb_twostage_wdog.sv
module tb_twostage_wdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s2_keep = 1'b0;
    logic        ctl_we = 1'b0;
    logic [4:0]  ctl_addr = '0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        ref_we = 1'b0;
    logic [4:0]  ref_addr = '0;
    logic [31:0] ref_wdata = '0;
    logic [63:0] cnt = 64'h0000_0000_FFFF_FFF0;
    logic [63:0] last_edge = '0;
    logic        irq, rst_req;
    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    twostage_wdog dut (
        .clk(clk), .rst_n(rst_n), .s2_keep_i(s2_keep),
        .ctl_we_i(ctl_we), .ctl_addr_i(ctl_addr), .ctl_wdata_i(ctl_wdata),
        .ctl_rdata_o(ctl_rdata), .ref_we_i(ref_we), .ref_addr_i(ref_addr),
        .ref_wdata_i(ref_wdata), .count_i(cnt), .irq_o(irq), .rst_req_o(rst_req)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired: act=%0d exp=<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        last_edge = cnt;
        cnt = cnt + 1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [4:0] a, input logic [31:0] d);
        ctl_we = 1'b1; ctl_addr = a; ctl_wdata = d;
        step();
        ctl_we = 1'b0;
    endtask

    task automatic kick(input logic [4:0] a, input logic [31:0] d);
        ref_we = 1'b1; ref_addr = a; ref_wdata = d;
        step();
        ref_we = 1'b0;
    endtask

    task automatic ctl_read(input logic [4:0] a, output logic [31:0] d);
        ctl_addr = a;
        #0.5;
        d = ctl_rdata;
    endtask

    task automatic cmp_read(output logic [63:0] v);
        logic [31:0] lo, hi;
        ctl_read(5'h10, lo);
        ctl_read(5'h14, hi);
        v = {hi, lo};
    endtask

    task automatic wait_irq(input int lim, output logic [63:0] e);
        e = '1;
        for (int k = 0; k < lim; k++) begin
            step();
            if (irq) begin e = last_edge; break; end
        end
    endtask

    initial begin
        logic [31:0] r;
        logic [63:0] c0, e1, e2, v, tgt;
        bit f2;
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        ctl_read(5'h00, r); chk(r == 0, "R1 status", r, 0);
        ctl_read(5'h08, r); chk(r == 0, "R1 interval", r, 0);
        cmp_read(v);        chk(v == 0, "R1 compare", v, 0);
        chk(!irq && !rst_req, "R1 outputs", {irq, rst_req}, 0);

        // R3 R4 sweep of intervals
        for (int off = 2; off <= 9; off++) begin
            ctl_write(5'h08, off);
            ctl_write(5'h00, 32'h1);
            c0 = last_edge;
            wait_irq(40, e1);
            chk(e1 == c0 + off, "R3 irq edge", e1, c0 + off);
            f2 = 0; e2 = '1;
            for (int k = 0; k < 40 && !f2; k++) begin
                step();
                if (rst_req) begin f2 = 1; e2 = last_edge; end
            end
            chk(e2 == c0 + 2 * off, "R4 reset edge", e2, c0 + 2 * off);
            step();
            chk(!rst_req, "R4 single pulse", rst_req, 0);
            if (off == 2) begin
                ctl_write(5'h00, 32'h1);
                ctl_read(5'h00, r); chk(r == 32'h5, "R8 s2 kept on enable", r, 5);
                // R9 read map with an unmapped address
                ctl_read(5'h0C, r); chk(r == 0, "R9 unmapped", r, 0);
            end
            ctl_write(5'h00, 32'h4);
            ctl_read(5'h00, r); chk(r == 0, "R8 s2 cleared", r, 0);
        end

        // R3 interval zero
        ctl_write(5'h08, 0);
        ctl_write(5'h00, 32'h1);
        c0 = last_edge;
        wait_irq(10, e1);
        chk(e1 == c0 + 1, "R3 zero interval irq", e1, c0 + 1);
        step();
        chk(rst_req == 1, "R4 zero interval reset", rst_req, 1);
        ctl_write(5'h00, 32'h4);

        // R5 refresh before expiry
        ctl_write(5'h08, 6);
        ctl_write(5'h00, 32'h1);
        c0 = last_edge;
        repeat (3) step();
        kick(5'h00, 32'hDEAD_BEEF);
        tgt = last_edge + 6;
        wait_irq(20, e1);
        chk(e1 == tgt, "R5 refresh delays irq", e1, tgt);
        // R5 other refresh address ignored
        kick(5'h04, 32'h0);
        chk(irq == 1, "R5 ignored address", irq, 1);
        kick(5'h00, 32'h1234_5678);
        chk(irq == 0, "R5 refresh clears irq", irq, 0);
        cmp_read(v);
        chk(v == last_edge + 6, "R5 compare rearm", v, last_edge + 6);

        // R6 interval write re-arms
        ctl_write(5'h08, 3);
        tgt = last_edge + 3;
        cmp_read(v); chk(v == tgt, "R6 compare", v, tgt);
        ctl_read(5'h08, r); chk(r == 3, "R6 interval read", r, 3);
        wait_irq(20, e1);
        chk(e1 == tgt, "R6 irq edge", e1, tgt);

        // R2 disable clears irq, R8 no timeout while disabled
        ctl_write(5'h00, 32'h4);
        chk(irq == 0, "R2 disable clears irq", irq, 0);
        f2 = 0;
        for (int k = 0; k < 30; k++) begin
            step();
            if (irq || rst_req) f2 = 1;
        end
        chk(!f2, "R8 idle when disabled", f2, 0);

        // R7 compare halves
        ctl_write(5'h14, 32'hA5A5_0001);
        ctl_write(5'h10, 32'h1234_5678);
        cmp_read(v); chk(v == 64'hA5A5_0001_1234_5678, "R7 readback", v, 64'hA5A5_0001_1234_5678);
        ctl_write(5'h08, 50);
        ctl_write(5'h00, 32'h1);
        tgt = last_edge + 20;
        ctl_write(5'h10, tgt[31:0]);
        wait_irq(40, e1);
        chk(e1 == tgt, "R7 direct compare fires", e1, tgt);

        // R1 reset hold input
        s2_keep = 1'b1; rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        ctl_read(5'h00, r); chk(r == 32'h4, "R1 s2 kept over reset", r, 4);
        chk(!irq, "R1 irq after reset", irq, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule